// File: doc/BRIEF.md
# SDRAM Transfer Descriptor Scanner

This block walks a circular list of transfer descriptors in a shared on-chip word memory and hands each live descriptor to an SDRAM burst engine. Each descriptor is two consecutive words. The first word (the control word) carries the host quad address, the direction and the burst size. The second word carries the SDRAM address. Software fills the SDRAM word first and the control word last, so a nonzero control word marks a ready descriptor. When the engine reports completion, the scanner writes zero over the control word. That zero both frees the slot and tells software the transfer is done. No separate status or head/tail pointers are needed.

The memory port is a valid/ready request channel. A request (read or write) stays on the pins with its address, direction and data unchanged until the cycle where `mem_req_valid` and `mem_req_ready` are both high. Read data comes back on a valid-only response channel. The scanner keeps at most one read outstanding and always accepts the response, so that channel has no back-pressure. The engine side is a plain one-cycle `eng_start` pulse plus decoded fields, and a one-cycle `eng_done` pulse in return. The list base is a plain input. It is sampled after reset and at every wrap.

Top module: `cmdlist_scanner`

## Requirements
- R1: The first memory request after reset is a read of the control word at `list_base`.
- R2: A control word equal to zero is skipped. The next request reads the control word two words further on, and no engine start occurs.
- R3: A control word equal to 8 (bit 3 set, all other bits clear) is the end marker. The next request reads the control word at the current `list_base`, and the marker word is never rewritten.
- R4: A nonzero control word whose size code (bits 2..0) is 0 and which is not the end marker is skipped like an empty entry and is left unchanged in memory.
- R5: For a control word with size code n in 1..7, the scanner reads the SDRAM word at the next address. It then pulses `eng_start` with these fields: `eng_quads` = 2^(n-1), `eng_write` = bit 3, `eng_host_quad` = bits 16..4 of the control word, and `eng_sdram_addr` = the low 25 bits of the SDRAM word. Bits 31..17 of the control word are ignored.
- R6: From `eng_start` until `eng_done`, the engine fields stay stable and no memory request is raised.
- R7: After `eng_done`, the scanner writes zero to the descriptor's control word. The following request reads the next descriptor's control word.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, direction and write data stay unchanged.
- R9: `eng_start` lasts exactly one cycle and is not raised again before `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_base | input | 16 | Word address of the first descriptor |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_wdata | output | 32 | Write data (always zero for completions) |
| mem_rsp_valid | input | 1 | Read data valid (one per accepted read) |
| mem_rsp_data | input | 32 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the burst engine |
| eng_write | output | 1 | 1 = write to SDRAM, 0 = read from SDRAM |
| eng_host_quad | output | 13 | Host quad address |
| eng_sdram_addr | output | 25 | SDRAM address |
| eng_quads | output | 7 | Number of 16-byte quads (1 to 64) |
| eng_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The assertions take three things for granted about the environment. `eng_done` arrives only after a start and never in the start cycle itself. A read response arrives only for an accepted read and no earlier than the cycle after acceptance. SDRAM addresses are aligned to the burst size. The bench's memory model returns each response one to three cycles after acceptance, and its engine model answers one to five cycles after the start it observed. Software-side edits are made the way the list protocol demands: the SDRAM word first, then the control word, only in slots that are empty. The list base is changed only while a transfer is in progress, so no wrap can straddle the change.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Control word layout
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned DIR_BIT  = 3;
  localparam int unsigned HOST_LSB = 4;
  localparam logic [31:0] END_WORD = 32'd8;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_SD_REQ,
    ST_SD_WAIT,
    ST_KICK,
    ST_BUSY,
    ST_CLEAR
  } scan_state_e;

  typedef enum logic [1:0] {
    KIND_SKIP,
    KIND_WRAP,
    KIND_XFER
  } entry_kind_e;

endpackage

// File: rtl/desc_classify.sv
module desc_classify
  import scan_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HOST_W = 13,
  localparam int unsigned QCNT_W = (1 << CODE_W) - 1
) (
  input  logic [DATA_W-1:0] word_i,
  output entry_kind_e       kind_o,
  output logic              write_o,
  output logic [HOST_W-1:0] host_o,
  output logic [QCNT_W-1:0] quads_o
);

  logic [CODE_W-1:0] code;
  assign code    = word_i[CODE_W-1:0];
  assign write_o = word_i[DIR_BIT];
  assign host_o  = word_i[HOST_LSB +: HOST_W];

  // A size code n maps to a count of 2^(n-1): one-hot in bit n-1.
  for (genvar g = 0; g < QCNT_W; g++) begin : g_qdec
    assign quads_o[g] = (code == CODE_W'(g + 1));
  end

  always_comb begin
    if (word_i == '0)                           kind_o = KIND_SKIP;
    else if (word_i == DATA_W'(END_WORD))       kind_o = KIND_WRAP;
    else if (code == '0)                        kind_o = KIND_SKIP;
    else                                        kind_o = KIND_XFER;
  end

endmodule

// File: rtl/list_walker.sv
module list_walker #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned ENTRY_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] ctrl_addr_o,
  output logic [ADDR_W-1:0] sd_addr_o
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ENTRY_WORDS);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (step_i) ptr_q <= ptr_q + STRIDE;
  end

  assign ctrl_addr_o = ptr_q;
  assign sd_addr_o   = ptr_q + ADDR_W'(1);

endmodule

// File: rtl/cmdlist_scanner.sv
module cmdlist_scanner
  import scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HOST_W = 13,
  parameter int unsigned SD_W   = 25,
  localparam int unsigned QCNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] list_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              eng_start,
  output logic              eng_write,
  output logic [HOST_W-1:0] eng_host_quad,
  output logic [SD_W-1:0]   eng_sdram_addr,
  output logic [QCNT_W-1:0] eng_quads,
  input  logic              eng_done
);

  scan_state_e state_q, state_d;

  entry_kind_e       kind;
  logic              dec_write;
  logic [HOST_W-1:0] dec_host;
  logic [QCNT_W-1:0] dec_quads;
  logic [ADDR_W-1:0] ctrl_addr, sd_addr;
  logic              ptr_load, ptr_step;
  logic              accepted, latch_ctrl, latch_sd;

  desc_classify #(
    .DATA_W(DATA_W),
    .HOST_W(HOST_W)
  ) u_classify (
    .word_i (mem_rsp_data),
    .kind_o (kind),
    .write_o(dec_write),
    .host_o (dec_host),
    .quads_o(dec_quads)
  );

  list_walker #(
    .ADDR_W     (ADDR_W),
    .ENTRY_WORDS(2)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load),
    .step_i     (ptr_step),
    .base_i     (list_base),
    .ctrl_addr_o(ctrl_addr),
    .sd_addr_o  (sd_addr)
  );

  assign accepted = mem_req_valid && mem_req_ready;

  always_comb begin
    state_d    = state_q;
    ptr_load   = 1'b0;
    ptr_step   = 1'b0;
    latch_ctrl = 1'b0;
    latch_sd   = 1'b0;
    unique case (state_q)
      ST_LOAD: begin
        ptr_load = 1'b1;
        state_d  = ST_HDR_REQ;
      end
      ST_HDR_REQ: if (accepted) state_d = ST_HDR_WAIT;
      ST_HDR_WAIT: begin
        if (mem_rsp_valid) begin
          unique case (kind)
            KIND_WRAP: begin
              ptr_load = 1'b1;
              state_d  = ST_HDR_REQ;
            end
            KIND_XFER: begin
              latch_ctrl = 1'b1;
              state_d    = ST_SD_REQ;
            end
            default: begin
              ptr_step = 1'b1;
              state_d  = ST_HDR_REQ;
            end
          endcase
        end
      end
      ST_SD_REQ: if (accepted) state_d = ST_SD_WAIT;
      ST_SD_WAIT: begin
        if (mem_rsp_valid) begin
          latch_sd = 1'b1;
          state_d  = ST_KICK;
        end
      end
      ST_KICK: state_d = ST_BUSY;
      ST_BUSY: if (eng_done) state_d = ST_CLEAR;
      ST_CLEAR: begin
        if (accepted) begin
          ptr_step = 1'b1;
          state_d  = ST_HDR_REQ;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_LOAD;
    else        state_q <= state_d;
  end

  // Decoded descriptor fields, held from capture until the next descriptor.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_write     <= 1'b0;
      eng_host_quad <= '0;
      eng_quads     <= '0;
    end else if (latch_ctrl) begin
      eng_write     <= dec_write;
      eng_host_quad <= dec_host;
      eng_quads     <= dec_quads;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        eng_sdram_addr <= '0;
    else if (latch_sd) eng_sdram_addr <= mem_rsp_data[SD_W-1:0];
  end

  assign eng_start     = (state_q == ST_KICK);
  assign mem_req_valid = (state_q == ST_HDR_REQ) || (state_q == ST_SD_REQ) ||
                         (state_q == ST_CLEAR);
  assign mem_req_write = (state_q == ST_CLEAR);
  assign mem_req_addr  = (state_q == ST_SD_REQ) ? sd_addr : ctrl_addr;
  assign mem_req_wdata = '0;

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HOST_W = 13,
  parameter int unsigned SD_W   = 25,
  parameter int unsigned QCNT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              eng_start,
  input logic              eng_write,
  input logic [HOST_W-1:0] eng_host_quad,
  input logic [SD_W-1:0]   eng_sdram_addr,
  input logic [QCNT_W-1:0] eng_quads,
  input logic              eng_done
);

  logic busy_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (eng_start) busy_q <= 1'b1;
    else if (eng_done)  busy_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata)); // R8

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !eng_start); // R9

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !mem_req_valid); // R6

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $stable(eng_write) && $stable(eng_host_quad) &&
      $stable(eng_sdram_addr) && $stable(eng_quads)); // R6

  AST_QUADS_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $countones(eng_quads) == 1); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata == '0); // R7

endmodule

bind cmdlist_scanner scan_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_W(HOST_W), .SD_W(SD_W), .QCNT_W(QCNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .eng_start(eng_start), .eng_write(eng_write),
  .eng_host_quad(eng_host_quad), .eng_sdram_addr(eng_sdram_addr),
  .eng_quads(eng_quads), .eng_done(eng_done)
);

// File: tb/cmdlist_scanner_tb_top.sv
module cmdlist_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] list_base = 16'd8;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        eng_start, eng_write;
  logic [12:0] eng_host_quad;
  logic [24:0] eng_sdram_addr;
  logic [6:0]  eng_quads;
  logic        eng_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdlist_scanner dut_i (.*);

  logic [31:0] mem [MEM_WORDS];
  int checks = 0, fails = 0, starts = 0, reqs = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 expects a control read, 1 the SDRAM read,
  // 2 the start, 3 the completion write. m_ptr < 0 means "expect list_base".
  int          m_ptr = -1, m_phase = 0;
  bit          m_write;
  int          m_host, m_quads, m_sd;
  int          rsp_cnt = 0, eng_cnt = 0;
  bit          eng_busy = 1'b0;
  logic [31:0] rsp_hold;
  bit          prev_stall = 1'b0;
  logic [15:0] prev_addr;
  logic        prev_write;

  task automatic model_accept(input logic [15:0] a, input logic wr, input logic [31:0] d);
    int exp_a;
    exp_a = (m_ptr < 0) ? int'(list_base) : m_ptr;
    reqs++;
    if (m_phase == 0) begin
      chk(!wr && a == 16'(exp_a), "R1/R2/R3 control read address", a, exp_a);
      m_ptr = exp_a;
      if (d == 32'd8) m_ptr = -1;
      else if (d == 0 || d[2:0] == 3'd0) m_ptr = m_ptr + 2;
      else begin
        m_write = d[3]; m_host = int'(d[16:4]); m_quads = 1 << (d[2:0] - 1);
        m_phase = 1;
      end
    end else if (m_phase == 1) begin
      chk(!wr && a == 16'(m_ptr + 1), "R5 SDRAM word read", a, m_ptr + 1);
      m_sd = int'(d[24:0]);
      m_phase = 2;
    end else if (m_phase == 3) begin
      chk(wr && a == 16'(m_ptr) && mem_req_wdata == 0, "R7 completion write", a, m_ptr);
      mem[a[5:0]] = mem_req_wdata;
      m_ptr = m_ptr + 2;
      m_phase = 0;
    end else begin
      chk(1'b0, "R6 request while engine owns descriptor", a, 0);
    end
  endtask

  initial begin : driver
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        chk(!mem_req_valid && !eng_start, "R1 reset quiet", {mem_req_valid, eng_start}, 0);
        continue;
      end
      // R8: a stalled request must persist unchanged
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_write,
            "R8 stalled request held", mem_req_addr, prev_addr);
      // read response channel
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_hold;
        end
      end
      // engine model
      eng_done = 1'b0;
      if (eng_busy) begin
        chk(!mem_req_valid && !eng_start, "R6/R9 quiet while busy", {mem_req_valid, eng_start}, 0);
        chk(eng_write == m_write && int'(eng_host_quad) == m_host &&
            int'(eng_quads) == m_quads && int'(eng_sdram_addr) == m_sd,
            "R6 fields stable while busy", eng_quads, m_quads);
        eng_cnt--;
        if (eng_cnt == 0) begin
          eng_done = 1'b1;
          eng_busy = 1'b0;
          m_phase  = 3;
        end
      end else if (eng_start) begin
        starts++;
        chk(m_phase == 2, "R9 start only after SDRAM read", m_phase, 2);
        chk(eng_write == m_write, "R5 direction", eng_write, m_write);
        chk(int'(eng_host_quad) == m_host, "R5 host quad", eng_host_quad, m_host);
        chk(int'(eng_quads) == m_quads, "R5 quad count", eng_quads, m_quads);
        chk(int'(eng_sdram_addr) == m_sd, "R5 SDRAM address", eng_sdram_addr, m_sd);
        eng_busy = 1'b1;
        eng_cnt  = 1 + int'($urandom % 5);
      end
      // request channel
      mem_req_ready = ($urandom % 10) < 7;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      prev_write = mem_req_write;
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_write) begin
          rsp_hold = mem[mem_req_addr[5:0]];
          rsp_cnt  = 1 + int'($urandom % 3);
        end
        model_accept(mem_req_addr, mem_req_write, mem[mem_req_addr[5:0]]);
      end
    end
  end

  task automatic wait_starts(input int n);
    while (starts < n) @(negedge clk);
  endtask

  initial begin : main
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    mem[8]  = (32'h123 << 4) | 32'h8 | 32'd7;  mem[9]  = 32'h0000400;   // write, 64 quads
    mem[12] = (32'h055 << 4) | 32'd1;          mem[13] = 32'h7E01230;   // read, 1 quad, upper SD bits ignored
    mem[14] = 32'h40;                          mem[15] = 32'h1;         // size 0, not marker
    mem[16] = 32'hFFFF_ABC3;                   mem[17] = 32'h0000080;   // garbage high bits
    mem[18] = 32'd8;                                                     // end marker
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_starts(3);
    // software adds an entry into an empty slot: SDRAM word first
    @(negedge clk); mem[11] = 32'h0000200;
    @(negedge clk); mem[10] = (32'h0777 << 4) | 32'h8 | 32'd3;
    wait_starts(4);
    // build a second list and move the base while a transfer is in flight
    mem[32] = (32'h0A0 << 4) | 32'h8 | 32'd2;  mem[33] = 32'h20;
    mem[34] = (32'h111 << 4) | 32'd4;          mem[35] = 32'h1000;
    mem[36] = (32'h1F0 << 4) | 32'h8 | 32'd5;  mem[37] = 32'h4000;
    mem[38] = (32'h002 << 4) | 32'd6;          mem[39] = 32'h8000;
    mem[40] = 32'd8;
    while (!eng_busy) @(negedge clk);
    list_base = 16'd32;
    wait_starts(8);
    repeat (400) @(negedge clk);
    chk(starts == 8, "R2 no extra starts from empty entries", starts, 8);
    chk(mem[14] == 32'h40, "R4 size-0 word left unchanged", mem[14], 32'h40);
    chk(mem[18] == 32'd8 && mem[40] == 32'd8, "R3 end marker untouched", mem[40], 8);
    chk(mem[8] == 0 && mem[10] == 0 && mem[12] == 0 && mem[16] == 0,
        "R7 completed control words zeroed", mem[16], 0);
    chk(mem[32] == 0 && mem[34] == 0 && mem[36] == 0 && mem[38] == 0,
        "R3 new base list consumed", mem[38], 0);
    chk(mem[9] == 32'h400, "R7 SDRAM word not rewritten", mem[9], 32'h400);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=8 starts", starts);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule